// File: doc/BRIEF.md
# Modulo Timer with Buffered Reload

This block is a memory-mapped up-counting timer that software programs over a simple register bus. A prescaler divides the system clock by a power of two. On each resulting tick the counter advances from a programmable start value toward a programmable limit. When it reaches the limit, it jumps back to the start value and raises an overflow flag. That flag can be routed to an interrupt line.

The limit and start registers are double-buffered. Bus writes land in a holding buffer. The value the counter uses is refreshed from that buffer only while counting is switched off, so a write made during a run never disturbs the period in progress. Any write to the counter register, whatever its data, restarts the count at the current start value.

A typical one-shot or periodic sequence is:
1. Stop the clock.
2. Write the limit.
3. Write the counter to restart it.
4. Enable the clock with the wanted prescale and interrupt enable.
5. Clear the flag in the interrupt handler by reading it as 1 and writing 0.

Top module: `modtmr_top`

## Requirements
- R1: The counter register at offset 0x04 reads as the 16-bit count, zero-extended to 32 bits.
- R2: On each tick the counter increments by one, unless it equals the active limit; in that case it loads the active start value instead.
- R3: The overflow flag (control bit 7) is set on the tick where the counter moves from the limit to the start value, so one period lasts (limit − start + 1) ticks.
- R4: A bus write to the counter register loads the active start value, regardless of the data written.
- R5: Writes to the limit (0x08) and start (0x4C) registers go into buffers that read back the written value. The active copies take the buffered values only while the clock-select field is zero.
- R6: After reset, the registers read as follows:
  - counter: 0
  - control word: 0
  - start value: 0
  - limit: 0xFFFF
  - irq: 0
- R7: The clock-select field (control bits 4:3) enables counting when nonzero, for example value 1 or 2. When it is zero, the counter holds its value.
- R8: The prescale field (control bits 2:0) gives one tick every 2^ps clock cycles, with the first tick 2^ps cycles after counting is enabled. The divider restarts whenever the clock-select field is zero.
- R9: The irq output equals the overflow flag ANDed with the interrupt enable (control bit 6). It changes on the same clock edge as the bits that drive it.
- R10: Writing 0 to the flag clears it only if the flag was read as 1 since the last control write. Writing 1 to the flag has no effect. An overflow in the same cycle as a clear wins.
- R11: Reads at offsets other than 0x00, 0x04, 0x08 and 0x4C return 0, and unused bits read as 0. Read data is registered and valid in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered overflow interrupt |

## Verification
The assertions assume that a write strobe and a read strobe never occur in the same cycle. They also assume that the prescale field is changed only while the clock-select field is zero, so the divider never starts above its terminal count. The directed stimulus meets both assumptions:
- Every bus access is a single strobe on its own cycle.
- The prescale field is set only in the same write that starts counting from a stopped state.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] OFS_CTRL = 8'h00;
  localparam logic [AW-1:0] OFS_CNT  = 8'h04;
  localparam logic [AW-1:0] OFS_MOD  = 8'h08;
  localparam logic [AW-1:0] OFS_INIT = 8'h4C;
  localparam int PS_LSB   = 0;
  localparam int SEL_LSB  = 3;
  localparam int SEL_W    = 2;
  localparam int IE_BIT   = 6;
  localparam int FLAG_BIT = 7;
endpackage

// File: rtl/modtmr_presc.sv
module modtmr_presc #(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic [PSW-1:0] ps,
  output logic           tick
);
  localparam int DIVW = (1 << PSW) - 1;

  logic [DIVW-1:0] div;
  logic [DIVW-1:0] mask;

  always_comb begin
    mask = ({{(DIVW-1){1'b0}}, 1'b1} << ps) - {{(DIVW-1){1'b0}}, 1'b1};
    tick = run && (div == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) div <= '0;
    else if (div == mask) div <= '0;
    else div <= div + 1'b1;
  end

  assert_div_restart_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (div == '0));
endmodule

// File: rtl/modtmr_count.sv
module modtmr_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cnt_wr,
  input  logic [CW-1:0] init_act,
  input  logic [CW-1:0] mod_act,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  logic at_lim;

  always_comb begin
    at_lim = (cnt == mod_act);
    ovf    = tick && at_lim && !cnt_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt_wr) cnt <= init_act;
    else if (tick) cnt <= at_lim ? init_act : cnt + 1'b1;
  end

  assert_cnt_write_loads_init_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(init_act)));
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && (cnt != mod_act)) |=> (cnt == $past(cnt) + 1'b1));
  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == $past(init_act)));
endmodule

// File: rtl/modtmr_regs.sv
module modtmr_regs
  import modtmr_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [CW-1:0]  cnt,
  input  logic           ovf,
  output logic [DW-1:0]  rdata,
  output logic           irq,
  output logic           run,
  output logic [PSW-1:0] ps,
  output logic [CW-1:0]  mod_act,
  output logic [CW-1:0]  init_act,
  output logic           cnt_wr
);
  logic [SEL_W-1:0] sel_q;
  logic             ie_q, flag_q, armed_q;
  logic             flag_d, ie_d;
  logic [CW-1:0]    mod_buf, init_buf;
  logic             wr_ctrl, wr_mod, wr_init, rd_ctrl;
  logic [DW-1:0]    rd_mux;

  always_comb begin
    wr_ctrl = wr_en && (addr == OFS_CTRL);
    cnt_wr  = wr_en && (addr == OFS_CNT);
    wr_mod  = wr_en && (addr == OFS_MOD);
    wr_init = wr_en && (addr == OFS_INIT);
    rd_ctrl = rd_en && (addr == OFS_CTRL);
    run     = (sel_q != '0);

    flag_d = flag_q;
    if (wr_ctrl && !wdata[FLAG_BIT] && armed_q) flag_d = 1'b0;
    if (ovf) flag_d = 1'b1;
    ie_d = wr_ctrl ? wdata[IE_BIT] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      ps      <= '0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq    <= flag_d && ie_d;
      if (wr_ctrl) begin
        sel_q   <= wdata[SEL_LSB +: SEL_W];
        ps      <= wdata[PS_LSB +: PSW];
        armed_q <= 1'b0;
      end else if (rd_ctrl && flag_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_buf  <= '1;
      init_buf <= '0;
      mod_act  <= '1;
      init_act <= '0;
    end else begin
      if (wr_mod)  mod_buf  <= wdata[CW-1:0];
      if (wr_init) init_buf <= wdata[CW-1:0];
      if (!run) begin
        mod_act  <= mod_buf;
        init_act <= init_buf;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CTRL: begin
        rd_mux[PS_LSB +: PSW]    = ps;
        rd_mux[SEL_LSB +: SEL_W] = sel_q;
        rd_mux[IE_BIT]           = ie_q;
        rd_mux[FLAG_BIT]         = flag_q;
      end
      OFS_CNT:  rd_mux[CW-1:0] = cnt;
      OFS_MOD:  rd_mux[CW-1:0] = mod_buf;
      OFS_INIT: rd_mux[CW-1:0] = init_buf;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assert_flag_on_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    ovf |=> flag_q);
  assert_active_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    run |=> ($stable(mod_act) && $stable(init_act)));
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    !flag_q |-> !irq);
  assert_write_one_keeps_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata[FLAG_BIT] && !ovf) |=> (flag_q == $past(flag_q)));
  assert_unarmed_keeps_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !armed_q && flag_q) |=> flag_q);
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
  import modtmr_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);
  logic           run, tick, cnt_wr, ovf;
  logic [PSW-1:0] ps;
  logic [CW-1:0]  mod_act, init_act, cnt;

  modtmr_regs #(.CW(CW), .PSW(PSW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .ovf(ovf), .rdata(rdata), .irq(irq),
    .run(run), .ps(ps), .mod_act(mod_act), .init_act(init_act),
    .cnt_wr(cnt_wr)
  );

  modtmr_presc #(.PSW(PSW)) u_presc (
    .clk(clk), .rst(rst), .run(run), .ps(ps), .tick(tick)
  );

  modtmr_count #(.CW(CW)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr),
    .init_act(init_act), .mod_act(mod_act), .cnt(cnt), .ovf(ovf)
  );

  assert_stopped_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));
  assert_no_tick_when_stopped_R7: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);
endmodule

// File: tb/modtmr_top_test.sv
module modtmr_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0, checks = 0, cycnt = 0, last_edge = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_MOD = 8'h08, A_INIT = 8'h4C;

  modtmr_top uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .irq(irq));

  always #4 clk = ~clk;
  always @(posedge clk) cycnt <= cycnt + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; last_edge = cycnt + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; d = int'(rdata);
  endtask

  task automatic model(input int ini, input int lim, input int st, input int t,
                       output int c, output int ov);
    c = st; ov = 0;
    for (int i = 0; i < t; i++) begin
      if (c == lim) begin c = ini; ov++; end
      else c = (c + 1) & 32'hFFFF;
    end
  endtask

  task automatic prepare(input int ini, input int lim);
    int d;
    bus_write(A_MOD, lim);
    bus_write(A_INIT, ini);
    bus_write(A_CNT, 32'hBEEF);
    bus_read(A_CTRL, d);
    bus_write(A_CTRL, 0);
  endtask

  // returns tick count of the run
  task automatic run_for(input int ps, input int sel, input int k, input int ie, output int t);
    int en;
    bus_write(A_CTRL, (ie << 6) | (sel << 3) | ps);
    en = last_edge;
    repeat (k) @(negedge clk);
    bus_write(A_CTRL, ie << 6);
    t = (last_edge - en) >> ps;
  endtask

  task automatic t_reset();
    int d;
    bus_read(A_CTRL, d); check("R6 ctrl", d, 0);
    bus_read(A_CNT, d);  check("R6 cnt", d, 0);
    bus_read(A_MOD, d);  check("R6 mod", d, 32'hFFFF);
    bus_read(A_INIT, d); check("R6 init", d, 0);
    check("R6 irq", int'(irq), 0);
    bus_read(8'h10, d);  check("R11 unmapped", d, 0);
  endtask

  task automatic t_wrap();
    int t, c, ov, d;
    prepare(2, 5);
    run_for(0, 1, 3, 0, t);
    model(2, 5, 2, t, c, ov);
    bus_read(A_CNT, d);  check("R2 wrap count", d, c);
    bus_read(A_CTRL, d); check("R3 flag after wrap", d, (ov > 0) ? 32'h80 : 0);
  endtask

  task automatic t_period();
    int t, c, ov, d;
    prepare(0, 3);
    run_for(0, 1, 1, 0, t);
    check("R3 ticks", t, 3);
    bus_read(A_CNT, d);  check("R3 at limit", d, 3);
    bus_read(A_CTRL, d); check("R3 no flag yet", d, 0);
    run_for(0, 1, 0, 0, t);
    model(0, 3, 3, t, c, ov);
    bus_read(A_CNT, d);  check("R3 after period", d, c);
    bus_read(A_CTRL, d); check("R3 flag set", d, 32'h80);
  endtask

  task automatic t_prescale();
    int t, d, tot;
    prepare(0, 32'hFFFF);
    run_for(2, 1, 10, 0, t);
    tot = t;
    check("R8 ps2 ticks", t, 3);
    run_for(2, 1, 10, 0, t);
    tot += t;
    bus_read(A_CNT, d); check("R8 divider restart", d, tot);
    prepare(0, 32'hFFFF);
    run_for(7, 1, 300, 0, t);
    bus_read(A_CNT, d); check("R8 ps7", d, 2);
  endtask

  task automatic t_cntwr();
    int d;
    prepare(32'h20, 32'h40);
    bus_write(A_CNT, 32'hFFFF1234);
    bus_read(A_CNT, d); check("R4 write loads init", d, 32'h20);
    check("R1 upper zero", d >>> 16, 0);
  endtask

  task automatic t_shadow();
    int en, t, c, ov, d;
    prepare(0, 9);
    bus_write(A_CTRL, 32'h08);
    en = last_edge;
    bus_write(A_MOD, 2);
    bus_write(A_CTRL, 0);
    t = last_edge - en;
    model(0, 9, 0, t, c, ov);
    bus_read(A_CNT, d); check("R5 limit frozen while running", d, c);
    bus_read(A_MOD, d); check("R5 buffer readback", d, 2);
    bus_write(A_CNT, 0);
    run_for(0, 1, 1, 0, t);
    model(0, 2, 0, t, c, ov);
    bus_read(A_CNT, d); check("R5 limit loaded when stopped", d, c);
  endtask

  task automatic t_sel();
    int t, d;
    prepare(0, 32'hFFFF);
    run_for(0, 2, 4, 0, t);
    bus_read(A_CNT, d); check("R7 sel2 counts", d, t);
    repeat (10) @(negedge clk);
    bus_read(A_CNT, d); check("R7 stopped holds", d, t);
  endtask

  task automatic t_flag();
    int t, d;
    prepare(0, 1);
    run_for(0, 1, 1, 1, t);
    @(negedge clk);
    check("R9 irq with enable", int'(irq), 1);
    bus_write(A_CTRL, 0);
    check("R9 irq masked", int'(irq), 0);
    bus_read(A_CTRL, d); check("R10 unarmed write keeps flag", d, 32'h80);
    bus_write(A_CTRL, 32'hC0);
    check("R9 irq re-enabled", int'(irq), 1);
    bus_read(A_CTRL, d); check("R10 write one no effect", d, 32'hC0);
    bus_write(A_CTRL, 32'h40);
    check("R9 irq after clear", int'(irq), 0);
    bus_read(A_CTRL, d); check("R10 armed clear", d, 32'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_wrap();
    t_period();
    t_prescale();
    t_cntwr();
    t_shadow();
    t_sel();
    t_flag();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule